// File: doc/BRIEF.md
# Card Status Change Interrupt Controller

This block watches the live signals of one removable-card socket (two card-detect lines, ready/busy, two battery-voltage-detect lines, plus power-valid, power-active and write-protect) and turns their transitions into sticky change flags. Software reads the live state and the flags through a small indexed register port. It chooses which flags may interrupt, and it chooses how flags are cleared: either the act of reading the change register clears them, or software writes ones back to clear chosen bits.

Every live input passes through a synchronizer before its edges are detected. A per-event mask and a master enable form an interrupt request from the flags. The interrupt output either pulses for one cycle when the request rises or follows the request as a level, as selected by a global control bit.

Top module: `csc_irq_ctl`

## Requirements
- R1: Register 0 (read-only) returns the synchronized live inputs: bit 7 power-valid, bit 6 power-active, bit 5 ready, bit 4 write-protect, bits 3:2 card-detect, bits 1:0 battery-voltage-detect.
- R2: Change register (register 1) bit 3 sets when either synchronized card-detect bit changes in either direction.
- R3: Change register bit 2 sets on either edge of the synchronized ready input.
- R4: Change register bit 1 sets on a falling edge of battery-voltage-detect bit 1, and bit 0 sets on a falling edge of battery-voltage-detect bit 0. Rising edges set nothing.
- R5: A change flag, once set, stays set until the active clear policy clears it.
- R6: With global control (register 5) bit 2 at 0, a read of register 1 returns the flags and clears all of them. A write to register 1 has no effect in this mode.
- R7: With register 5 bit 2 at 1, reads of register 1 do not clear it, and writing register 1 clears exactly the flag bits written as 1.
- R8: An event that arrives in the same cycle as a clear leaves its flag set.
- R9: Writing 1 to bit 5 of register 4 sets change bit 3. Register 4 always reads as 0.
- R10: The interrupt request is the OR of (change flags AND the mask in register 2 bits 3:0), gated by the enable in register 3 bit 4. With the enable at 0 the output stays low.
- R11: In pulse mode (register 5 bit 1 at 0), the interrupt output is high for exactly one cycle each time the request rises. It stays low while the request stays high.
- R12: In level mode (register 5 bit 1 at 1), the interrupt output stays high while the request is high and falls after the flags are cleared.
- R13: After reset, all flags, mask, enable and global control bits are 0, register 0 reads 0 with inputs at 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Live power-valid indication |
| pwr_on_i | input | 1 | Live card power-active indication |
| rdy_i | input | 1 | Live ready/busy from the card |
| wp_i | input | 1 | Live write-protect switch |
| det_i | input | 2 | Live card-detect lines |
| bvd_i | input | 2 | Live battery-voltage-detect lines |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt output, pulse or level |

## Verification
The assertions assume that read and write strobes are never raised together and that each strobe lasts one cycle per access. They also assume that live inputs change no faster than the synchronizer can follow, so that every edge is seen. The stimulus changes inputs only at falling clock edges and holds each pattern for several cycles. It issues one register access at a time with a single-cycle strobe. The clear-collision case lines up a read with the cycle in which a synchronized edge lands, two edges after the input moved.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int EV_N    = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CHG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_IGC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CDG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_GLB  = 3'd5;

  localparam int EV_CD  = 3;
  localparam int EV_RDY = 2;
  localparam int EV_BW  = 1;
  localparam int EV_BD  = 0;

  localparam int GLB_LEVEL = 1;
  localparam int GLB_WB    = 2;
  localparam int IGC_IE    = 4;
  localparam int CDG_SWCD  = 5;

  typedef struct packed {
    logic       pwr_ok;
    logic       pwr_on;
    logic       rdy;
    logic       wp;
    logic [1:0] det;
    logic [1:0] bvd;
  } live_t;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_rest
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/csc_evdet.sv
module csc_evdet
  import csc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  live_t           live_i,
  input  logic            sw_cd_i,
  output logic [EV_N-1:0] ev_o
);
  live_t prev_q;
  live_t prev_d;

  always_comb begin
    prev_d = live_i;
    ev_o = '0;
    ev_o[EV_CD]  = (live_i.det != prev_q.det) | sw_cd_i;
    ev_o[EV_RDY] = live_i.rdy ^ prev_q.rdy;
    ev_o[EV_BW]  = prev_q.bvd[1] & ~live_i.bvd[1];
    ev_o[EV_BD]  = prev_q.bvd[0] & ~live_i.bvd[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // rising battery lines never raise a battery event
  p_bvd_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_q.bvd[0] && live_i.bvd[0]) |-> !ev_o[EV_BD]);
endmodule

// File: rtl/csc_flags.sv
module csc_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[i] |=> flag_q[i]);
      p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    end
  endgenerate
endmodule

// File: rtl/csc_irq.sv
module csc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic level_i,
  output logic irq_o
);
  logic req_q, irq_q;
  logic irq_d;

  always_comb begin
    if (level_i) irq_d = req_i;
    else         irq_d = req_i & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= req_i;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && irq_o) |=> !irq_o);
  p_level_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && req_i) |=> irq_o);
endmodule

// File: rtl/csc_irq_ctl.sv
module csc_irq_ctl
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok_i,
  input  logic              pwr_on_i,
  input  logic              rdy_i,
  input  logic              wp_i,
  input  logic [1:0]        det_i,
  input  logic [1:0]        bvd_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  live_t           live_raw, live_s;
  logic [EV_N-1:0] ev, flags, clr;
  logic [EV_N-1:0] mask_q, mask_d;
  logic            ie_q, ie_d, lvl_q, lvl_d, wb_q, wb_d;
  logic            sw_cd, req;
  logic            unused_wdata;

  assign live_raw = '{pwr_ok: pwr_ok_i, pwr_on: pwr_on_i, rdy: rdy_i,
                      wp: wp_i, det: det_i, bvd: bvd_i};
  assign unused_wdata = ^{reg_wdata[7:6]};

  csc_sync #(.W($bits(live_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(live_raw), .q_o(live_s));

  assign sw_cd = reg_wr && (reg_addr == A_CDG) && reg_wdata[CDG_SWCD];

  csc_evdet u_evdet (
    .clk(clk), .rst_n(rst_n), .live_i(live_s), .sw_cd_i(sw_cd), .ev_o(ev));

  always_comb begin
    clr = '0;
    if (wb_q) begin
      if (reg_wr && reg_addr == A_CHG) clr = reg_wdata[EV_N-1:0];
    end else begin
      if (reg_rd && reg_addr == A_CHG) clr = '1;
    end
  end

  csc_flags #(.N(EV_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(clr), .flag_o(flags));

  // configuration next state with explicit write enables
  always_comb begin
    mask_d = mask_q;
    ie_d   = ie_q;
    lvl_d  = lvl_q;
    wb_d   = wb_q;
    if (reg_wr) begin
      case (reg_addr)
        A_MASK:  mask_d = reg_wdata[EV_N-1:0];
        A_IGC:   ie_d   = reg_wdata[IGC_IE];
        A_GLB: begin
          lvl_d = reg_wdata[GLB_LEVEL];
          wb_d  = reg_wdata[GLB_WB];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ie_q   <= 1'b0;
      lvl_q  <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ie_q   <= ie_d;
      lvl_q  <= lvl_d;
      wb_q   <= wb_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata = live_s;
      A_CHG:  reg_rdata[EV_N-1:0] = flags;
      A_MASK: reg_rdata[EV_N-1:0] = mask_q;
      A_IGC:  reg_rdata[IGC_IE] = ie_q;
      A_GLB: begin
        reg_rdata[GLB_LEVEL] = lvl_q;
        reg_rdata[GLB_WB]    = wb_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign req = ie_q && |(flags & mask_q);

  csc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .level_i(lvl_q), .irq_o(irq_o));

  p_ie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |=> !irq_o);
  p_wb_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_q && !reg_wr) |=> (flags & $past(flags)) == $past(flags));
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_q && reg_rd && reg_addr == A_CHG && ev == '0) |=> flags == '0);
endmodule

// File: tb/sim_csc_irq_ctl.sv
module sim_csc_irq_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] live;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_o;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  csc_irq_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .pwr_ok_i(live[7]), .pwr_on_i(live[6]), .rdy_i(live[5]), .wp_i(live[4]),
    .det_i(live[3:2]), .bvd_i(live[1:0]),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  // {live pattern, expected change flags relative to previous pattern}
  localparam logic [11:0] VEC [8] = '{12'hC30, 12'hCF8, 12'hEF4, 12'hED2,
                                      12'hEC1, 12'hC7C, 12'hD61, 12'h052};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    repeat (n) begin tick(); if (irq_o) c++; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int c;
    rst_n = 1'b0; live = 8'h00; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R13 reset state
    check("R13 irq", {7'd0, irq_o}, 8'h00);
    rd(3'd0, v); check("R13 status", v, 8'h00);
    rd(3'd1, v); check("R13 change", v, 8'h00);
    rd(3'd5, v); check("R13 global", v, 8'h00);

    // table walk, read-clear mode: R1 R2 R3 R4 R6
    foreach (VEC[i]) begin
      live = VEC[i][11:4];
      tick(5);
      rd(3'd0, v); check("R1 status", v, VEC[i][11:4]);
      rd(3'd1, v); check("R2/R3/R4 change", v, {4'h0, VEC[i][3:0]});
      rd(3'd1, v); check("R6 cleared by read", v, 8'h00);
    end

    // R6: write to change register ignored in read-clear mode
    live[5] = ~live[5]; tick(5);
    wr(3'd1, 8'h0F);
    rd(3'd1, v); check("R6 write ignored", v, 8'h04);

    // R7 write-back mode
    wr(3'd5, 8'h04);
    live[5] = ~live[5]; tick(5);
    rd(3'd1, v); check("R7 first read", v, 8'h04);
    rd(3'd1, v); check("R7 read keeps", v, 8'h04);
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R7 other bit untouched", v, 8'h04);
    wr(3'd1, 8'h04);
    rd(3'd1, v); check("R7 write clears", v, 8'h00);

    // R8 event coincides with read-clear
    wr(3'd5, 8'h00);
    live[5] = ~live[5];
    tick(2);
    rd(3'd1, v); check("R8 clearing read", v, 8'h00);
    rd(3'd1, v); check("R8 event wins", v, 8'h04);

    // R9 software card-detect event
    wr(3'd4, 8'h20);
    rd(3'd1, v); check("R9 sw cd flag", v, 8'h08);
    rd(3'd4, v); check("R9 reads zero", v, 8'h00);

    // R11 pulse mode
    wr(3'd2, 8'h04); wr(3'd3, 8'h10);
    live[5] = ~live[5];
    count_irq(10, c); check("R11 one pulse", 8'(c), 8'd1);
    live[5] = ~live[5];
    count_irq(10, c); check("R11 no pulse while high", 8'(c), 8'd0);
    rd(3'd1, v);
    live[5] = ~live[5];
    count_irq(10, c); check("R11 pulse after clear", 8'(c), 8'd1);
    rd(3'd1, v);

    // R12 level mode
    wr(3'd5, 8'h02);
    live[5] = ~live[5];
    tick(6); check("R12 level high", {7'd0, irq_o}, 8'h01);
    count_irq(5, c); check("R12 level held", 8'(c), 8'd5);
    rd(3'd1, v);
    tick(2); check("R12 level drops", {7'd0, irq_o}, 8'h00);

    // R10 masked event does not interrupt
    live[1:0] = 2'b11; tick(6); rd(3'd1, v);
    live[1] = 1'b0; tick(6);
    check("R10 masked irq", {7'd0, irq_o}, 8'h00);
    rd(3'd1, v); check("R10 flag still recorded", v, 8'h02);

    // R10 master enable off
    wr(3'd3, 8'h00);
    live[5] = ~live[5]; tick(6);
    check("R10 enable off", {7'd0, irq_o}, 8'h00);
    wr(3'd3, 8'h10);
    tick(2); check("R10 enable on", {7'd0, irq_o}, 8'h01);

    finish_run();
  end
endmodule